// File: doc/BRIEF.md
# Multi-Latency Issue Hazard Gate

This block sits in the decode stage of a pipeline that has four kinds of execution unit. There is a single-cycle integer unit, a pipelined multiplier, a pipelined adder and a divider that is not pipelined. Each cycle the block looks at the instruction waiting in decode and returns one verdict: issue it now, or hold it. An instruction is described by its unit, one destination register and two source registers.

An instruction is held for any of four reasons:
- the divider is still working on an earlier divide;
- the single register-file write port is already claimed for the cycle in which this instruction would write back;
- an earlier instruction still in flight will write the same destination;
- a source register is still waiting for a result that has not yet reached writeback.

The block keeps this state internally. A shift register records one bit for each future writeback cycle. Each register has a pending flag and a count of the cycles left until its writeback. A countdown tracks the divider. The verdict is combinational from this state and the current inputs. State changes only in a cycle where the instruction issues.

Top module: `issue_hazard_gate`

## Requirements
- R1: After reset nothing is in flight, so a valid instruction of any unit issues in the first cycle it is presented.
- R2: When `instValid` is 0, both `issue` and `stall` are 0 and no state changes: a dependent instruction presented afterwards issues at once.
- R3: When `instValid` is 1, exactly one of `issue` and `stall` is 1.
- R4: Unit encoding on `instUnit` is 0 integer, 1 multiply, 2 add, 3 divide. An instruction issued in cycle t writes back in cycle t+L, where L is INT_LAT (1), MUL_LAT (7), ADD_LAT (4) or DIV_LAT (24) respectively.
- R5: An instruction whose source matches the destination of an in-flight instruction stalls until that producer's writeback cycle and issues in it. A consumer of an integer result issues in the very next cycle.
- R6: An instruction whose destination matches the destination of an in-flight instruction stalls until that instruction's writeback cycle.
- R7: An instruction stalls when its writeback cycle t+L is already claimed by an earlier instruction. Examples: an integer op presented 6 cycles after a multiply, or an add presented 3 cycles after a multiply.
- R8: A divide presented while an earlier divide is in progress stalls. It issues DIV_LAT cycles after the earlier divide issued. Other units are not held by the busy divider.
- R9: A stalled instruction claims nothing. It reserves no writeback slot and marks no register pending.
- R10: Instructions with distinct writeback cycles and independent registers issue back to back. One example is multiply, multiply, add on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is waiting in decode |
| instUnit | input | 2 | Target unit: 0 integer, 1 multiply, 2 add, 3 divide |
| instDst | input | REG_W | Destination register index |
| instSrcA | input | REG_W | First source register index |
| instSrcB | input | REG_W | Second source register index |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction is held in decode this cycle |

## Verification
Producer and consumer pairs are run on every unit type. Counting the stall cycles exactly tells a correct latency apart from one that is off by one in either direction.

Some patterns have no shared registers and are spaced so that only writeback cycles collide. These separate the write-port check from the register checks. Back-to-back divides separate the divider-busy check from the port check, and a divide followed by an integer op shows that the busy divider holds no other unit.

A stalled instruction followed by one that reuses its destination shows that a rejected instruction leaves no trace. An idle cycle carrying a conflicting payload shows that an invalid slot has no effect.

// File: rtl/issue_hazard_pkg.sv
`timescale 1ns/1ps
package issue_hazard_pkg;

  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_MUL = 2'd1,
    UNIT_ADD = 2'd2,
    UNIT_DIV = 2'd3
  } unitSel_e;

  // Strobes from the control half to the state-keeping half.
  typedef struct packed {
    logic     issue;
    unitSel_e unit;
  } issueStrobes_t;

  // Cycles from issue to writeback for a unit.
  function automatic int unitLatency(unitSel_e u, int latInt, int latMul, int latAdd, int latDiv);
    case (u)
      UNIT_INT: return latInt;
      UNIT_MUL: return latMul;
      UNIT_ADD: return latAdd;
      default:  return latDiv;
    endcase
  endfunction

endpackage

// File: rtl/issue_hazard_dp.sv
`timescale 1ns/1ps
module issue_hazard_dp
  import issue_hazard_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5,
  parameter int INT_LAT  = 1,
  parameter int MUL_LAT  = 7,
  parameter int ADD_LAT  = 4,
  parameter int DIV_LAT  = 24,
  parameter int MAX_LAT  = 24,
  parameter int LAT_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  issueStrobes_t       stb,
  input  logic [REG_W-1:0]    dst,
  output logic [NUM_REGS-1:0] pendVec,
  output logic [MAX_LAT:0]    resvBits,
  output logic [3:0]          unitSlotBusy,
  output logic                divBusy
);

  logic [LAT_W-1:0] issueLat;
  logic [MAX_LAT:0] claimMask;
  logic [MAX_LAT:0] resvQ;
  logic [LAT_W-1:0] divCnt;

  always_comb begin
    issueLat  = LAT_W'(unitLatency(stb.unit, INT_LAT, MUL_LAT, ADD_LAT, DIV_LAT));
    claimMask = stb.issue ? ((MAX_LAT+1)'(1) << issueLat) : '0;
  end

  // Bit k set: the write port is taken k cycles from now; bit 0 is this cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) resvQ <= '0;
    else        resvQ <= (resvQ | claimMask) >> 1;
  end
  assign resvBits = resvQ;

  // Per-unit view of the slot that unit would claim.
  for (genvar u = 0; u < 4; u++) begin : g_slot
    localparam int SLOT = unitLatency(unitSel_e'(u), INT_LAT, MUL_LAT, ADD_LAT, DIV_LAT);
    assign unitSlotBusy[u] = resvQ[SLOT];
  end

  // Pending flag and cycles-to-writeback per register.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic             pendR;
    logic [LAT_W-1:0] cntR;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pendR <= 1'b0;
        cntR  <= '0;
      end else if (stb.issue && dst == REG_W'(r)) begin
        cntR  <= issueLat - LAT_W'(1);
        pendR <= (issueLat != LAT_W'(1));
      end else if (cntR != '0) begin
        cntR  <= cntR - LAT_W'(1);
        pendR <= (cntR != LAT_W'(1));
      end
    end
    assign pendVec[r] = pendR;
  end

  // Divider occupancy countdown.
  always_ff @(posedge clk) begin
    if (!rst_n)                                divCnt <= '0;
    else if (stb.issue && stb.unit == UNIT_DIV) divCnt <= LAT_W'(DIV_LAT - 1);
    else if (divCnt != '0)                     divCnt <= divCnt - LAT_W'(1);
  end
  assign divBusy = (divCnt != '0);

endmodule

// File: rtl/issue_hazard_ctrl.sv
`timescale 1ns/1ps
module issue_hazard_ctrl
  import issue_hazard_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5
) (
  input  logic                instValid,
  input  unitSel_e            unit,
  input  logic [REG_W-1:0]    dst,
  input  logic [REG_W-1:0]    srcA,
  input  logic [REG_W-1:0]    srcB,
  input  logic [NUM_REGS-1:0] pendVec,
  input  logic [3:0]          unitSlotBusy,
  input  logic                divBusy,
  output issueStrobes_t       stb,
  output logic                issue,
  output logic                stall
);

  logic divHaz, portHaz, wawHaz, rawHaz, anyHaz;

  always_comb begin
    divHaz  = (unit == UNIT_DIV) && divBusy;
    portHaz = unitSlotBusy[unit];
    wawHaz  = pendVec[dst];
    rawHaz  = pendVec[srcA] || pendVec[srcB];
    anyHaz  = divHaz || portHaz || wawHaz || rawHaz;
    issue   = instValid && !anyHaz;
    stall   = instValid && anyHaz;
    stb.issue = issue;
    stb.unit  = unit;
  end

endmodule

// File: rtl/issue_hazard_gate.sv
`timescale 1ns/1ps
module issue_hazard_gate
  import issue_hazard_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int INT_LAT  = 1,
  parameter int MUL_LAT  = 7,
  parameter int ADD_LAT  = 4,
  parameter int DIV_LAT  = 24,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int MAX_LAT = (DIV_LAT > MUL_LAT ? DIV_LAT : MUL_LAT) > (ADD_LAT > INT_LAT ? ADD_LAT : INT_LAT)
                         ? (DIV_LAT > MUL_LAT ? DIV_LAT : MUL_LAT) : (ADD_LAT > INT_LAT ? ADD_LAT : INT_LAT),
  localparam int LAT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instValid,
  input  logic [1:0]       instUnit,
  input  logic [REG_W-1:0] instDst,
  input  logic [REG_W-1:0] instSrcA,
  input  logic [REG_W-1:0] instSrcB,
  output logic             issue,
  output logic             stall
);

  issueStrobes_t       stb;
  logic [NUM_REGS-1:0] pendVec;
  logic [MAX_LAT:0]    resvBits;
  logic [3:0]          unitSlotBusy;
  logic                divBusy;

  issue_hazard_ctrl #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) ctrl_i (
    .instValid   (instValid),
    .unit        (unitSel_e'(instUnit)),
    .dst         (instDst),
    .srcA        (instSrcA),
    .srcB        (instSrcB),
    .pendVec     (pendVec),
    .unitSlotBusy(unitSlotBusy),
    .divBusy     (divBusy),
    .stb         (stb),
    .issue       (issue),
    .stall       (stall)
  );

  issue_hazard_dp #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .INT_LAT(INT_LAT), .MUL_LAT(MUL_LAT),
    .ADD_LAT(ADD_LAT), .DIV_LAT(DIV_LAT), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)
  ) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .dst         (instDst),
    .pendVec     (pendVec),
    .resvBits    (resvBits),
    .unitSlotBusy(unitSlotBusy),
    .divBusy     (divBusy)
  );

endmodule

// File: rtl/issue_hazard_chk.sv
`timescale 1ns/1ps
module issue_hazard_chk
  import issue_hazard_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5,
  parameter int INT_LAT  = 1,
  parameter int MUL_LAT  = 7,
  parameter int ADD_LAT  = 4,
  parameter int DIV_LAT  = 24,
  parameter int MAX_LAT  = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                instValid,
  input logic [1:0]          instUnit,
  input logic [REG_W-1:0]    instDst,
  input logic [REG_W-1:0]    instSrcA,
  input logic [REG_W-1:0]    instSrcB,
  input logic                issue,
  input logic                stall,
  input logic [NUM_REGS-1:0] pendVec,
  input logic [MAX_LAT:0]    resvBits
);

  localparam int CNT_W = $clog2(DIV_LAT + 1);
  localparam int IDX_W = $clog2(MAX_LAT + 1);

  logic [IDX_W-1:0] chkLat;
  logic             divIssue;
  logic [CNT_W-1:0] sinceDiv;

  always_comb begin
    chkLat   = IDX_W'(unitLatency(unitSel_e'(instUnit), INT_LAT, MUL_LAT, ADD_LAT, DIV_LAT));
    divIssue = issue && (unitSel_e'(instUnit) == UNIT_DIV);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              sinceDiv <= CNT_W'(DIV_LAT);
    else if (divIssue)                       sinceDiv <= CNT_W'(1);
    else if (sinceDiv < CNT_W'(DIV_LAT))     sinceDiv <= sinceDiv + CNT_W'(1);
  end

  // R3
  exclusive_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && stall));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instValid |-> (!issue && !stall));

  // R5
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (!pendVec[instSrcA] && !pendVec[instSrcB]));

  // R6
  waw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !pendVec[instDst]);

  // R7
  port_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !resvBits[chkLat]);

  // R8
  div_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    divIssue |-> (sinceDiv >= CNT_W'(DIV_LAT)));

  // R4
  latency_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && chkLat > IDX_W'(1)) |=> pendVec[$past(instDst)]);

endmodule

bind issue_hazard_gate issue_hazard_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .INT_LAT(INT_LAT), .MUL_LAT(MUL_LAT),
  .ADD_LAT(ADD_LAT), .DIV_LAT(DIV_LAT), .MAX_LAT(MAX_LAT)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .instValid(instValid),
  .instUnit (instUnit),
  .instDst  (instDst),
  .instSrcA (instSrcA),
  .instSrcB (instSrcB),
  .issue    (issue),
  .stall    (stall),
  .pendVec  (pendVec),
  .resvBits (resvBits)
);

// File: tb/issue_hazard_gate_tb.sv
`timescale 1ns/1ps
module issue_hazard_gate_tb_top;

  localparam int U_INT = 0, U_MUL = 1, U_ADD = 2, U_DIV = 3;
  localparam int L_MUL = 7, L_ADD = 4, L_DIV = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instValid = 1'b0;
  logic [1:0] instUnit = '0;
  logic [4:0] instDst = '0, instSrcA = '0, instSrcB = '0;
  logic       issue, stall;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  issue_hazard_gate dut_i (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .instUnit(instUnit),
    .instDst(instDst), .instSrcA(instSrcA), .instSrcB(instSrcB),
    .issue(issue), .stall(stall)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic present(input bit v, input int u, input int d, input int a, input int b,
                         output bit iss, output bit stl);
    @(negedge clk);
    instValid = v;
    instUnit  = u[1:0];
    instDst   = d[4:0];
    instSrcA  = a[4:0];
    instSrcB  = b[4:0];
    #1;
    iss = issue;
    stl = stall;
  endtask

  task automatic idle(input int n);
    bit i, s;
    for (int k = 0; k < n; k++) present(1'b0, 0, 0, 0, 0, i, s);
  endtask

  // Present until issued; count stall cycles and any cycle with neither verdict.
  task automatic waitIssue(input int u, input int d, input int a, input int b,
                           output int stalls, output int silent);
    bit i, s;
    stalls = 0;
    silent = 0;
    for (int k = 0; k < 200; k++) begin
      present(1'b1, u, d, a, b, i, s);
      if (i) break;
      if (s) stalls++;
      else   silent++;
    end
  endtask

  task automatic expectIssue(input int u, input int d, input int a, input int b, input string req);
    bit i, s;
    present(1'b1, u, d, a, b, i, s);
    check(i && !s, req, "issue expected", {i, s}, 2);
  endtask

  task automatic expectStall(input int u, input int d, input int a, input int b, input string req);
    bit i, s;
    present(1'b1, u, d, a, b, i, s);
    check(!i && s, req, "stall expected", {i, s}, 1);
  endtask

  task automatic testReset();
    bit i, s;
    present(1'b0, U_MUL, 1, 1, 1, i, s);
    check(!i && !s, "R2", "idle after reset", {i, s}, 0);
    expectIssue(U_DIV, 1, 2, 3, "R1");
    idle(30);
    expectIssue(U_MUL, 2, 3, 4, "R1");
    idle(30);
  endtask

  task automatic testRawMul();
    int st, sl;
    expectIssue(U_MUL, 4, 1, 2, "R5");
    waitIssue(U_ADD, 5, 4, 6, st, sl);
    check(st == L_MUL - 1, "R4", "multiply consumer stall cycles", st, L_MUL - 1);
    check(sl == 0, "R3", "cycles with no verdict while valid", sl, 0);
    idle(30);
  endtask

  task automatic testIntBypass();
    expectIssue(U_INT, 7, 1, 2, "R5");
    expectIssue(U_INT, 8, 7, 7, "R5");
    idle(30);
  endtask

  task automatic testWaw();
    int st, sl;
    expectIssue(U_ADD, 8, 1, 2, "R6");
    waitIssue(U_INT, 8, 3, 4, st, sl);
    check(st == L_ADD - 1, "R6", "same-destination stall cycles", st, L_ADD - 1);
    idle(30);
  endtask

  task automatic testPort();
    expectIssue(U_MUL, 9, 1, 2, "R7");
    idle(5);
    expectStall(U_INT, 10, 1, 2, "R7");
    expectIssue(U_INT, 10, 1, 2, "R7");
    idle(30);
    expectIssue(U_MUL, 9, 1, 2, "R7");
    idle(2);
    expectStall(U_ADD, 11, 3, 4, "R7");
    expectIssue(U_ADD, 11, 3, 4, "R7");
    idle(30);
  endtask

  task automatic testDiv();
    int st, sl;
    expectIssue(U_DIV, 12, 1, 2, "R8");
    waitIssue(U_DIV, 13, 3, 4, st, sl);
    check(st == L_DIV - 1, "R8", "second divide stall cycles", st, L_DIV - 1);
    idle(30);
    expectIssue(U_DIV, 12, 1, 2, "R8");
    expectIssue(U_INT, 14, 1, 2, "R8");
    waitIssue(U_INT, 15, 12, 1, st, sl);
    check(st == L_DIV - 2, "R4", "divide consumer stall cycles", st, L_DIV - 2);
    idle(30);
  endtask

  task automatic testStalledLeavesNoTrace();
    expectIssue(U_MUL, 16, 1, 2, "R9");
    expectStall(U_ADD, 17, 16, 1, "R9");
    expectIssue(U_INT, 17, 1, 2, "R9");
    expectIssue(U_INT, 18, 17, 17, "R9");
    idle(30);
  endtask

  task automatic testInvalid();
    bit i, s;
    present(1'b0, U_MUL, 19, 1, 2, i, s);
    check(!i && !s, "R2", "invalid slot verdict", {i, s}, 0);
    expectIssue(U_INT, 20, 19, 19, "R2");
    expectIssue(U_MUL, 21, 1, 2, "R2");
    present(1'b0, U_ADD, 22, 21, 21, i, s);
    check(!i && !s, "R2", "invalid slot with hazard", {i, s}, 0);
    idle(30);
  endtask

  task automatic testBackToBack();
    expectIssue(U_MUL, 23, 1, 2, "R10");
    expectIssue(U_MUL, 24, 3, 4, "R10");
    expectIssue(U_ADD, 25, 5, 6, "R10");
    idle(30);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testRawMul();
    testIntBypass();
    testWaw();
    testPort();
    testDiv();
    testStalledLeavesNoTrace();
    testInvalid();
    testBackToBack();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule